// File: doc/BRIEF.md
# Flash Instruction Prefetch Buffer Controller

This block sits between a processor's instruction-fetch port and a slow flash array built from two interleaved banks. The flash delivers a 256-bit line of eight 32-bit words per access. Even-numbered words come from one bank and odd-numbered words from the other. The block keeps these lines in tagged line buffers and serves 32-bit reads from them. A read that hits is answered in the cycle it is presented. A read that misses holds `rsp_ready` low while the line is fetched. The fetch takes a fixed base latency plus a programmable wait-state count, which must be matched to the processor clock.

A runtime configuration input selects the replacement scheme:
- **Four-buffer mode** (the reset default) uses all four buffers with least-recently-used replacement. Each buffer carries a 2-bit age.
- **Two-buffer mode** restricts the block to two buffers that are filled alternately. This gives a fixed, repeatable timing pattern.

Changing the mode, or pulsing `flush`, drops every stored line. An optional sequential autofill fetches the line after a demand fill when the flash is idle and that line is not already held.

The controller state machine has four states:
- `S_IDLE` serves hits and starts a demand fill on a miss (transition *miss_start*).
- `S_DEMAND` waits for the flash and writes the line (transition *fill_done*).
- `S_SEQ_CHECK` is a one-cycle decision point. It can start another demand fill (*miss_start*), start an autofill (*auto_start*), or return to idle (*auto_skip*).
- `S_AUTOFILL` serves hits while the next line streams in, and returns to idle on *auto_done*.

A flush or mode change forces `S_IDLE` from any state (*flush_abort*).

Top module: `pfb_ctrl`

## Requirements
- R1: After reset no line is held, `rsp_ready` is low while `req_valid` is low, and the first request of any address misses.
- R2: A request whose line is held returns in the same cycle with `rsp_ready` high. Flash word address `a` reads as `{~a[15:0], a[15:0]}`. The word offset is `req_addr[2:0]`, and word k sits at line bits 32k+31:32k.
- R3: With the controller idle, a miss raises `rsp_ready` exactly `BASE_LAT + wait_states + 2` cycles after the request cycle, counting the request cycle as 0. Valid wait-state values are 0 to 5.
- R4: In four-buffer mode (`cfg_two_buf` = 0), a fill overwrites the buffer least recently hit or filled.
- R5: In two-buffer mode (`cfg_two_buf` = 1), only two buffers are used, and each fill goes to the buffer other than the one last filled, regardless of hits.
- R6: A one-cycle `flush` pulse invalidates every held line, so later requests to them miss.
- R7: A change of `cfg_two_buf` invalidates every held line and restarts the replacement order.
- R8: With `autofill_en` high, the cycle after a demand fill's response starts a fetch of the next sequential line if that line is absent. Hits are served while that fetch runs. With `autofill_en` low, no such fetch happens.
- R9: No autofill starts when the next line is already held, so a following miss sees the plain R3 latency.
- R10: A miss arriving during an autofill waits for that fetch to finish, then performs its own demand fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_buf | input | 1 | 0: four buffers with LRU replacement; 1: two alternating buffers |
| flush | input | 1 | Invalidate all held lines |
| autofill_en | input | 1 | Enable sequential next-line fetch |
| wait_states | input | 3 | Flash wait states, 0 to 5 |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | AW | Word address of the request |
| rsp_ready | output | 1 | Requested word is valid this cycle |
| rsp_data | output | 32 | Requested word |

## Verification
The assertions assume the following about the inputs:
- `wait_states` stays within 0 to 5 whenever a fetch starts.
- A request is held steady until the cycle in which it is answered.
- `flush` and mode changes never coincide with the write of a fetched line. The controller ensures this by suppressing the write.

The stimulus satisfies these assumptions in three ways. It holds each request until `rsp_ready` is seen. It changes wait states and mode only between requests. It uses only the six legal wait-state values.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 8;
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int OFS_W      = $clog2(LINE_WORDS);
    localparam int BANKS      = 2;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DEMAND,
        S_SEQ_CHECK,
        S_AUTOFILL
    } pfb_state_e;

    // Behavioural flash content: each word is derived from its own address.
    function automatic logic [WORD_W-1:0] flash_word(input logic [15:0] wa);
        return {~wa, wa};
    endfunction
endpackage

// File: rtl/pfb_flash.sv
module pfb_flash
    import pfb_pkg::*;
#(
    parameter int AW       = 10,
    parameter int BASE_LAT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abort,
    input  logic [AW-OFS_W-1:0]  line_addr,
    input  logic [2:0]           wait_states,
    output logic                 busy,
    output logic                 done,
    output logic [LINE_W-1:0]    line_data
);
    localparam int LAW   = AW - OFS_W;
    localparam int CNT_W = $clog2(BASE_LAT + 6) + 1;
    localparam int WPB   = LINE_WORDS / BANKS;

    logic [LAW-1:0]   addr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(BASE_LAT) + CNT_W'(wait_states);
            addr_q <= line_addr;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    // Two interleaved banks: bank b supplies words b, b+2, b+4, b+6.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        for (genvar k = 0; k < WPB; k++) begin : g_word
            localparam int W = k * BANKS + b;
            logic [AW-1:0] wa;
            assign wa = {addr_q, OFS_W'(W)};
            assign line_data[W*WORD_W +: WORD_W] = flash_word(16'(wa));
        end
    end

    assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    assert_ws_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (wait_states <= 3'd5));
endmodule

// File: rtl/pfb_repl.sv
module pfb_repl #(
    parameter int NBUF = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     two_mode,
    input  logic                     touch,
    input  logic                     fill,
    input  logic [$clog2(NBUF)-1:0]  touch_idx,
    output logic [$clog2(NBUF)-1:0]  victim_idx
);
    localparam int IDX_W = $clog2(NBUF);
    localparam int AGE_W = IDX_W;

    logic [AGE_W-1:0] age_q [NBUF];
    logic             ptr_q;
    logic [NBUF-1:0]  oldest;
    logic [IDX_W-1:0] lru_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) age_q[i] <= AGE_W'(NBUF - 1 - i);
            ptr_q <= 1'b0;
        end else if (clear) begin
            for (int i = 0; i < NBUF; i++) age_q[i] <= AGE_W'(NBUF - 1 - i);
            ptr_q <= 1'b0;
        end else begin
            if (touch && !two_mode) begin
                for (int i = 0; i < NBUF; i++) begin
                    if (IDX_W'(i) == touch_idx)            age_q[i] <= '0;
                    else if (age_q[i] < age_q[touch_idx])  age_q[i] <= age_q[i] + 1'b1;
                end
            end
            if (fill && two_mode) ptr_q <= ~touch_idx[0];
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_old
        assign oldest[g] = (age_q[g] == AGE_W'(NBUF - 1));
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (oldest[i]) lru_idx = IDX_W'(i);
        end
        victim_idx = two_mode ? IDX_W'(ptr_q) : lru_idx;
    end

    assert_single_lru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);
    assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (two_mode && fill && !clear) |=> (!two_mode || victim_idx != $past(touch_idx)));
endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
    import pfb_pkg::*;
#(
    parameter int AW       = 10,
    parameter int BASE_LAT = 1,
    parameter int NBUF     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_two_buf,
    input  logic              flush,
    input  logic              autofill_en,
    input  logic [2:0]        wait_states,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    output logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data
);
    localparam int LAW   = AW - OFS_W;
    localparam int IDX_W = $clog2(NBUF);

    pfb_state_e state_q, state_d;

    logic [LAW-1:0]    tag_q  [NBUF];
    logic [LINE_W-1:0] line_q [NBUF];
    logic [NBUF-1:0]   valid_q;
    logic [NBUF-1:0]   en_mask;
    logic [NBUF-1:0]   hit_vec;
    logic [NBUF-1:0]   next_vec;
    logic              mode_q;
    logic [LAW-1:0]    fill_line_q;

    logic [LAW-1:0]    req_line;
    logic [OFS_W-1:0]  req_ofs;
    logic [LAW-1:0]    next_line;
    logic [LAW-1:0]    start_line;
    logic              hit;
    logic              next_present;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  victim_idx;
    logic              flush_all;
    logic              fill_we;
    logic              flash_start;
    logic              flash_busy;
    logic              flash_done;
    logic [LINE_W-1:0] flash_line;
    logic              touch;
    logic [IDX_W-1:0]  touch_idx;

    assign req_line  = req_addr[AW-1:OFS_W];
    assign req_ofs   = req_addr[OFS_W-1:0];
    assign next_line = fill_line_q + LAW'(1);
    assign flush_all = flush || (cfg_two_buf != mode_q);
    assign fill_we   = flash_done && !flush_all &&
                       ((state_q == S_DEMAND) || (state_q == S_AUTOFILL));

    for (genvar i = 0; i < NBUF; i++) begin : g_cmp
        assign en_mask[i]  = !mode_q || (i < 2);
        assign hit_vec[i]  = valid_q[i] && en_mask[i] && (tag_q[i] == req_line);
        assign next_vec[i] = valid_q[i] && en_mask[i] && (tag_q[i] == next_line);
    end

    assign hit          = |hit_vec;
    assign next_present = |next_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    pfb_flash #(.AW(AW), .BASE_LAT(BASE_LAT)) u_flash (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (flash_start),
        .abort       (flush_all),
        .line_addr   (start_line),
        .wait_states (wait_states),
        .busy        (flash_busy),
        .done        (flash_done),
        .line_data   (flash_line)
    );

    assign touch     = fill_we || rsp_ready;
    assign touch_idx = fill_we ? victim_idx : hit_idx;

    pfb_repl #(.NBUF(NBUF)) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush_all),
        .two_mode   (mode_q),
        .touch      (touch),
        .fill       (fill_we),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and flash launch
    always_comb begin
        state_d     = state_q;
        flash_start = 1'b0;
        start_line  = req_line;
        if (flush_all) begin
            state_d = S_IDLE;                       // flush_abort
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid && !hit && !flash_busy) begin
                        flash_start = 1'b1;         // miss_start
                        state_d     = S_DEMAND;
                    end
                end
                S_DEMAND: begin
                    if (fill_we) state_d = S_SEQ_CHECK;   // fill_done
                end
                S_SEQ_CHECK: begin
                    if (req_valid && !hit) begin
                        flash_start = 1'b1;         // miss_start
                        state_d     = S_DEMAND;
                    end else if (autofill_en && !next_present) begin
                        flash_start = 1'b1;         // auto_start
                        start_line  = next_line;
                        state_d     = S_AUTOFILL;
                    end else begin
                        state_d = S_IDLE;           // auto_skip
                    end
                end
                S_AUTOFILL: begin
                    if (fill_we) state_d = S_IDLE;  // auto_done
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // Response outputs
    always_comb begin
        rsp_ready = req_valid && hit && !flush_all && !fill_we;
        rsp_data  = line_q[hit_idx][WORD_W*req_ofs +: WORD_W];
    end

    // Buffer storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q     <= '0;
            mode_q      <= 1'b0;
            fill_line_q <= '0;
            for (int i = 0; i < NBUF; i++) begin
                tag_q[i]  <= '0;
                line_q[i] <= '0;
            end
        end else begin
            mode_q <= cfg_two_buf;
            if (flash_start) fill_line_q <= start_line;
            if (flush_all) begin
                valid_q <= '0;
            end else if (fill_we) begin
                valid_q[victim_idx] <= 1'b1;
                tag_q[victim_idx]   <= fill_line_q;
                line_q[victim_idx]  <= flash_line;
            end
        end
    end

    assert_ready_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> req_valid);
    assert_unique_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    assert_mode_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_two_buf != mode_q) |=> (valid_q == '0));
    assert_pair_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (valid_q[NBUF-1:2] == '0));
    assert_autofill_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_AUTOFILL && $past(state_q) == S_SEQ_CHECK) |-> $past(autofill_en));
endmodule

// File: tb/sim_pfb_ctrl.sv
module sim_pfb_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;

    logic          clk;
    logic          rst_n;
    logic          cfg_two_buf;
    logic          flush;
    logic          autofill_en;
    logic [2:0]    wait_states;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          rsp_ready;
    logic [31:0]   rsp_data;

    int checks   = 0;
    int failures = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] exp_w;
    string       exp_t;

    pfb_ctrl #(.AW(AW), .BASE_LAT(1), .NBUF(4)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_two_buf (cfg_two_buf),
        .flush       (flush),
        .autofill_en (autofill_en),
        .wait_states (wait_states),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .rsp_ready   (rsp_ready),
        .rsp_data    (rsp_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_word(input int a);
        logic [15:0] w;
        w = 16'(a);
        return {~w, w};
    endfunction

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Monitor: pops the scoreboard whenever the design answers.
    always @(negedge clk) begin
        if (rst_n && rsp_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected response actual=%h expected=none", rsp_data);
            end else begin
                exp_w = exp_q.pop_front();
                exp_t = tag_q.pop_front();
                if (rsp_data !== exp_w) begin
                    failures++;
                    $display("FAIL %s data actual=%h expected=%h", exp_t, rsp_data, exp_w);
                end
            end
        end
    end

    // Driver: pushes the expected word, holds the request until answered,
    // and checks the number of waiting cycles.
    task automatic do_req(input int line, input int ofs, input int exp_lat, input string req);
        int lat;
        int a;
        a = line * 8 + ofs;
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_addr  = AW'(a);
        exp_q.push_back(model_word(a));
        tag_q.push_back(req);
        lat = 0;
        forever begin
            @(negedge clk);
            if (rsp_ready) break;
            lat++;
            if (lat > 200) break;
        end
        checks++;
        if (lat != exp_lat) begin
            failures++;
            $display("FAIL %s latency actual=%0d expected=%0d", req, lat, exp_lat);
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic pulse_flush;
        @(posedge clk); #1 flush = 1'b1;
        @(posedge clk); #1 flush = 1'b0;
    endtask

    task automatic set_mode(input logic two);
        @(posedge clk); #1 cfg_two_buf = two;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        cfg_two_buf = 1'b0;
        flush       = 1'b0;
        autofill_en = 1'b0;
        wait_states = 3'd0;
        req_valid   = 1'b0;
        req_addr    = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_ready !== 1'b0) begin
            failures++;
            $display("FAIL R1 ready after reset actual=%b expected=0", rsp_ready);
        end

        // R1 R3: first access misses, ws=0 -> 3 cycles
        do_req(1, 0, 3, "R1 first miss");
        // R2: word positions inside a held line
        do_req(1, 7, 0, "R2 word7 hit");
        do_req(1, 3, 0, "R2 word3 hit");
        // R3 and R8 (autofill off: next line not fetched): ws=5 -> 8 cycles
        wait_states = 3'd5;
        do_req(2, 1, 8, "R3 R8 ws5 miss");
        wait_states = 3'd0;

        // R4: LRU in four-buffer mode
        pulse_flush();
        do_req(3, 0, 3, "R4 fill A");
        do_req(4, 0, 3, "R4 fill B");
        do_req(5, 0, 3, "R4 fill C");
        do_req(6, 0, 3, "R4 fill D");
        do_req(3, 2, 0, "R4 hit A");
        do_req(7, 0, 3, "R4 fill E");
        do_req(3, 4, 0, "R4 A kept");
        do_req(6, 6, 0, "R4 D kept");
        do_req(4, 1, 3, "R4 B evicted");

        // R6: flush drops held lines
        do_req(3, 5, 0, "R6 before flush");
        pulse_flush();
        do_req(3, 5, 3, "R6 after flush");

        // R7 R5: mode change drops lines; two-buffer alternation
        set_mode(1'b1);
        do_req(3, 0, 3, "R7 mode change miss");
        do_req(8, 0, 3, "R5 fill second");
        do_req(3, 1, 0, "R5 hit first");
        do_req(9, 0, 3, "R5 fill third");
        do_req(8, 2, 0, "R5 second kept");
        do_req(3, 3, 3, "R5 first replaced");
        set_mode(1'b0);
        do_req(9, 4, 3, "R7 back to four miss");

        // R8: autofill of the next line
        pulse_flush();
        autofill_en = 1'b1;
        wait_states = 3'd2;
        do_req(10, 0, 5, "R8 demand miss");
        repeat (12) @(posedge clk);
        do_req(11, 5, 0, "R8 next line prefetched");

        // R9: autofill skipped when next line is held
        pulse_flush();
        do_req(21, 0, 5, "R9 fill 21");
        repeat (12) @(posedge clk);
        do_req(20, 0, 5, "R9 fill 20");
        do_req(30, 0, 5, "R9 no extra fetch");
        // R10: miss during an autofill waits for it
        do_req(40, 0, 8, "R10 miss behind autofill");
        do_req(31, 7, 0, "R8 hit during autofill");
        repeat (10) @(posedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 unanswered actual=%0d expected=0", exp_q.size());
        end
        report();
        $finish;
    end
endmodule